// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block drives a 12-bit serial sampling converter from the host side over a three- or four-wire link. The link has a convert strobe, a shift clock, a result line coming back from the converter, and a configuration line going out to it. A one-clock start request makes the sequencer raise the convert strobe. It holds the strobe high for a programmable number of system clocks, which covers the conversion time. It then lowers the strobe and runs twelve shift-clock periods. During those periods it captures the result MSB first and shifts out a 2-bit multiplexer word.

The multiplexer word sent during a transfer selects the input for the following conversion, not for the one being read out. For that reason every result leaves the block with a tag. The tag is the word that was sent during the previous transfer, together with a flag that is low for the first result after reset, whose input is unknown.

A start request that arrives while a sequence is running is held in a single slot. That request is served once the current sequence ends. The shift clock is derived from the system clock by a half-period parameter. The conversion wait is a whole number of system clocks.

Top module: `adc_host_seq`

## Requirements
- R1: While reset is applied and right after it, the outputs conv_o, sck_o, sdi_o, busy_o, res_valid_o and res_cfg_known_o are all low.
- R2: A start request that is accepted in idle raises conv_o at the next clock edge. conv_o then stays high for exactly CONV_CYCLES system clocks before it falls.
- R3: sck_o is low whenever conv_o is high. The first sck_o rising edge comes SCK_HALF clocks after conv_o falls. Each high phase and each low phase of sck_o lasts SCK_HALF clocks. Every sequence has exactly 12 rising edges.
- R4: sdo_i is sampled at each rising edge of sck_o. The first bit sampled is the MSB. res_data_o presents the 12 sampled bits as a straight binary code.
- R5: cfg bit 1 (single-ended when 1, differential when 0) is on sdi_o at the first sck_o rising edge. cfg bit 0 is on sdi_o at the second rising edge, and sdi_o is 0 at all later rising edges. The codes are: 2'b10 single-ended input 0, 2'b11 single-ended input 1, 2'b00 differential with input 0 positive, 2'b01 differential with input 1 positive.
- R6: res_valid_o is a one-clock pulse. It is high in the cycle after the edge that produces the twelfth sck_o falling edge, which is CONV_CYCLES + 24*SCK_HALF clocks after the start edge.
- R7: res_cfg_o carries the cfg word sent in the previous sequence. res_cfg_known_o is low with the first result after reset and high with every later one.
- R8: A start request accepted while busy_o is high is held. conv_o rises again one clock after res_valid_o rises, and that new sequence sends the cfg word captured with the held request.
- R9: While a request is already held, further start requests are dropped. They cause no extra sequence.
- R10: busy_o is high from the clock after a start is accepted until the result is delivered. It is low in the cycle in which res_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-clock request for a conversion sequence |
| cfg_i | input | 2 | Multiplexer word sent with this request |
| sdo_i | input | 1 | Serial result bit from the converter |
| conv_o | output | 1 | Convert strobe |
| sck_o | output | 1 | Shift clock |
| sdi_o | output | 1 | Serial multiplexer word to the converter |
| busy_o | output | 1 | A sequence is in progress |
| res_valid_o | output | 1 | Result strobe, one clock |
| res_data_o | output | 12 | Conversion result, straight binary |
| res_cfg_o | output | 2 | Multiplexer word that selected this result's input |
| res_cfg_known_o | output | 1 | res_cfg_o is meaningful |

## Verification
Counted from the edge that accepts a start, conv_o is high one edge later and stays high for CONV_CYCLES clocks. The first shift-clock rise follows SCK_HALF clocks after conv_o falls. The result strobe comes 23*SCK_HALF clocks after that first rise. A held request raises conv_o one clock after the strobe. The bench drives on falling clock edges and counts falling edges in each phase. It compares the counted length against these figures, so every result is read in the exact cycle it is due. A converter model in the bench captures the two configuration bits at the first two shift-clock rises, and the captured word is checked against the request.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int RES_W = 12;
    localparam int CFG_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_seq_sck_gen.sv
module adc_seq_sck_gen #(
    parameter int HALF = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [PW-1:0] ph;
        logic          sck;
    } gen_t;

    gen_t q, d;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = run_i && (q.ph == PW'(HALF - 1));
        if (!run_i) begin
            d.ph  = '0;
            d.sck = 1'b0;
        end else if (wrap) begin
            d.ph  = '0;
            d.sck = ~q.sck;
        end else begin
            d.ph = q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_o  = q.sck;
    assign rise_o = wrap && !q.sck;
    assign fall_o = wrap && q.sck;
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             sdo_i,
    output logic             sdi_o,
    output logic [RES_W-1:0] data_o,
    output logic             last_o
);
    localparam int BW = $clog2(RES_W + 1);

    typedef struct packed {
        logic [RES_W-1:0] shreg;
        logic [CFG_W-1:0] cfg;
        logic [BW-1:0]    bits;
        logic             sdi;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.cfg  = cfg_i;
            d.bits = '0;
            d.sdi  = cfg_i[CFG_W-1];
        end else begin
            if (rise_i) d.shreg = {q.shreg[RES_W-2:0], sdo_i};
            if (fall_i) begin
                d.bits = q.bits + 1'b1;
                d.cfg  = {q.cfg[CFG_W-2:0], 1'b0};
                d.sdi  = q.cfg[CFG_W-2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdi_o  = q.sdi;
    assign data_o = q.shreg;
    assign last_o = fall_i && (q.bits == BW'(RES_W - 1));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 466
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             last_i,
    input  logic [RES_W-1:0] data_i,
    output logic             conv_o,
    output logic             run_o,
    output logic             load_o,
    output logic [CFG_W-1:0] load_cfg_o,
    output logic             busy_o,
    output logic             res_valid_o,
    output logic [RES_W-1:0] res_data_o,
    output logic [CFG_W-1:0] res_cfg_o,
    output logic             res_known_o
);
    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

    typedef struct packed {
        seq_state_e       state;
        logic [CW-1:0]    cnt;
        logic             pend;
        logic [CFG_W-1:0] pend_cfg;
        logic [CFG_W-1:0] cur_cfg;
        logic [CFG_W-1:0] prev_cfg;
        logic             prev_known;
        logic             conv;
        logic             valid;
        logic [RES_W-1:0] data;
        logic [CFG_W-1:0] tag;
        logic             known;
    } ctrl_t;

    ctrl_t q, d;
    logic launch;
    logic [CFG_W-1:0] launch_cfg;

    always_comb begin
        d          = q;
        d.valid    = 1'b0;
        launch     = 1'b0;
        launch_cfg = cfg_i;
        // one-deep hold slot; later requests while it is full are dropped
        if (q.state != ST_IDLE && start_i && !q.pend) begin
            d.pend     = 1'b1;
            d.pend_cfg = cfg_i;
        end
        case (q.state)
            ST_IDLE: begin
                if (q.pend) begin
                    launch     = 1'b1;
                    launch_cfg = q.pend_cfg;
                    d.pend     = start_i;
                    d.pend_cfg = cfg_i;
                end else if (start_i) begin
                    launch = 1'b1;
                end
                if (launch) begin
                    d.state   = ST_CONV;
                    d.cnt     = CW'(CONV_CYCLES - 1);
                    d.conv    = 1'b1;
                    d.cur_cfg = launch_cfg;
                end
            end
            ST_CONV: begin
                if (q.cnt == '0) begin
                    d.state = ST_XFER;
                    d.conv  = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_XFER: begin
                if (last_i) begin
                    d.state      = ST_IDLE;
                    d.valid      = 1'b1;
                    d.data       = data_i;
                    d.tag        = q.prev_cfg;
                    d.known      = q.prev_known;
                    d.prev_cfg   = q.cur_cfg;
                    d.prev_known = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign conv_o      = q.conv;
    assign run_o       = (q.state == ST_XFER);
    assign load_o      = launch;
    assign load_cfg_o  = launch_cfg;
    assign busy_o      = (q.state != ST_IDLE);
    assign res_valid_o = q.valid;
    assign res_data_o  = q.data;
    assign res_cfg_o   = q.tag;
    assign res_known_o = q.known;
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
    import adc_seq_pkg::*;
#(
    parameter int SCK_HALF    = 7,
    parameter int CONV_CYCLES = 466
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             sdo_i,
    output logic             conv_o,
    output logic             sck_o,
    output logic             sdi_o,
    output logic             busy_o,
    output logic             res_valid_o,
    output logic [RES_W-1:0] res_data_o,
    output logic [CFG_W-1:0] res_cfg_o,
    output logic             res_cfg_known_o
);
    localparam int HW = $clog2(CONV_CYCLES + 1);
    localparam int RW = $clog2(RES_W + 1);

    logic             run, load, rise, fall, last;
    logic [CFG_W-1:0] load_cfg;
    logic [RES_W-1:0] shf_data;

    adc_seq_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cfg_i      (cfg_i),
        .last_i     (last),
        .data_i     (shf_data),
        .conv_o     (conv_o),
        .run_o      (run),
        .load_o     (load),
        .load_cfg_o (load_cfg),
        .busy_o     (busy_o),
        .res_valid_o(res_valid_o),
        .res_data_o (res_data_o),
        .res_cfg_o  (res_cfg_o),
        .res_known_o(res_cfg_known_o)
    );

    adc_seq_sck_gen #(.HALF(SCK_HALF)) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .sck_o (sck_o),
        .rise_o(rise),
        .fall_o(fall)
    );

    adc_seq_shifter u_shf (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .cfg_i (load_cfg),
        .rise_i(rise),
        .fall_i(fall),
        .sdo_i (sdo_i),
        .sdi_o (sdi_o),
        .data_o(shf_data),
        .last_o(last)
    );

    // checking state: strobe-high length, rises per sequence, first result seen
    logic [HW-1:0] hi_cnt;
    logic [RW-1:0] rise_cnt;
    logic          seen_result;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt      <= '0;
            rise_cnt    <= '0;
            seen_result <= 1'b0;
        end else begin
            if (!conv_o)                          hi_cnt <= '0;
            else if (hi_cnt != HW'(CONV_CYCLES))  hi_cnt <= hi_cnt + 1'b1;
            if (load)      rise_cnt <= '0;
            else if (rise) rise_cnt <= rise_cnt + 1'b1;
            if (res_valid_o) seen_result <= 1'b1;
        end
    end

    a_r2_conv_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_o) |-> hi_cnt == HW'(CONV_CYCLES));

    a_r3_sck_quiet_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> !sck_o);

    a_r3_twelve_rises: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> rise_cnt == RW'(RES_W));

    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    a_r7_known_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_cfg_known_o == seen_result));

    a_r10_idle_at_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !busy_o);
endmodule

// File: tb/adc_host_seq_test.sv
module adc_host_seq_test;
    localparam int PERIOD = 10;
    localparam int H      = 2;
    localparam int C      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  cfg_i = 2'b00;
    logic        sdo_i;
    logic        conv_o, sck_o, sdi_o, busy_o, res_valid_o, res_cfg_known_o;
    logic [11:0] res_data_o;
    logic [1:0]  res_cfg_o;

    int checks = 0;
    int fails  = 0;
    logic [1:0] last_sent = 2'b00;
    bit         any_sent  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    adc_host_seq #(.SCK_HALF(H), .CONV_CYCLES(C)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i), .sdo_i(sdo_i),
        .conv_o(conv_o), .sck_o(sck_o), .sdi_o(sdi_o), .busy_o(busy_o),
        .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_cfg_o(res_cfg_o),
        .res_cfg_known_o(res_cfg_known_o)
    );

    // converter model: bit out on strobe fall and each shift-clock fall, word in on first two rises
    logic [11:0] adc_val = 12'h000;
    int          bit_idx = 12;
    int          n_rise  = 0;
    logic [1:0]  sdi_cap = 2'b00;

    always @(negedge conv_o) bit_idx = 0;
    always @(negedge sck_o)  bit_idx = bit_idx + 1;
    always @(posedge conv_o) n_rise = 0;
    always @(posedge sck_o) begin
        if (n_rise < 2) sdi_cap = {sdi_cap[0], sdi_o};
        n_rise = n_rise + 1;
    end
    assign sdo_i = (bit_idx < 12) ? adc_val[11 - bit_idx] : 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [1:0] cfg);
        start_i = 1'b1;
        cfg_i   = cfg;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_valid(output int w);
        w = 0;
        while (!res_valid_o && w < 5000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic check_result(input logic [11:0] val, input logic [1:0] cfg);
        chk(res_data_o == val, "R4", res_data_o, val);
        chk(sdi_cap == cfg, "R5", sdi_cap, cfg);
        chk(n_rise == 12, "R3", n_rise, 12);
        chk(res_cfg_known_o == any_sent, "R7", res_cfg_known_o, any_sent);
        if (any_sent) chk(res_cfg_o == last_sent, "R7", res_cfg_o, last_sent);
        last_sent = cfg;
        any_sent  = 1'b1;
    endtask

    task automatic test_reset;
        chk(conv_o == 1'b0 && sck_o == 1'b0 && sdi_o == 1'b0, "R1", {conv_o, sck_o, sdi_o}, 0);
        chk(busy_o == 1'b0 && res_valid_o == 1'b0 && res_cfg_known_o == 1'b0, "R1",
            {busy_o, res_valid_o, res_cfg_known_o}, 0);
    endtask

    task automatic do_cycle(input logic [1:0] cfg, input logic [11:0] val);
        int hi, lo, w;
        adc_val = val;
        pulse_start(cfg);
        chk(conv_o == 1'b1, "R2", conv_o, 1);
        chk(busy_o == 1'b1, "R10", busy_o, 1);
        hi = 0;
        while (conv_o && hi < 5000) begin
            @(negedge clk);
            hi++;
        end
        chk(hi == C, "R2", hi, C);
        lo = 0;
        while (!sck_o && lo < 5000) begin
            @(negedge clk);
            lo++;
        end
        chk(lo == H, "R3", lo, H);
        wait_valid(w);
        chk(w == 23 * H, "R6", w, 23 * H);
        chk(busy_o == 1'b0, "R10", busy_o, 0);
        check_result(val, cfg);
        @(negedge clk);
        chk(res_valid_o == 1'b0, "R6", res_valid_o, 0);
    endtask

    task automatic test_pending;
        int w, seen;
        adc_val = 12'h3C7;
        pulse_start(2'b11);
        repeat (3) @(negedge clk);
        pulse_start(2'b10);
        repeat (2) @(negedge clk);
        pulse_start(2'b00);   // R9: dropped, slot already full
        wait_valid(w);
        check_result(12'h3C7, 2'b11);
        adc_val = 12'h5A0;
        @(negedge clk);
        chk(conv_o == 1'b1, "R8", conv_o, 1);
        wait_valid(w);
        check_result(12'h5A0, 2'b10);
        seen = 0;
        repeat (60) begin
            @(negedge clk);
            if (conv_o || busy_o) seen++;
        end
        chk(seen == 0, "R9", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        do_cycle(2'b10, 12'hA5C);
        do_cycle(2'b11, 12'hFFF);
        do_cycle(2'b00, 12'h000);
        do_cycle(2'b01, 12'h801);
        repeat (4) @(negedge clk);
        test_pending;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R6: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule